// File: doc/BRIEF.md
# Daisy-Chain Serial Reset Sequencer

This block is the device-side sequencer for the serial control port of a memory chip. Several such chips share one reset line, one command line and one serial clock driven by a controller. The serial outputs of the chips form a chain that leads back to the controller's serial read input. The block samples its reset, command and serial-in pins only on the falling edge of the serial clock. While reset is sampled high, it clears its local control state and holds its serial output high, so the whole chain reads as ones.

When reset is sampled low again, each chip copies its serial input to its serial output through one register. The first chip in the chain has its serial input tied low. Its output therefore falls on the release edge, and that low level then moves one chip closer to the controller on every serial clock cycle. Each chip counts the falling edges from the release edge until its own serial input is seen low. That count is its position in the chain. The block latches the position as the device index and raises a valid flag. No strap pins are needed to number the devices.

Top module: `chain_pos_seq`

## Requirements
- R1: Every state change happens on a falling edge of `sckIn`. A change on `rstIn`, `cmdIn` or `sdiIn` between falling edges leaves all outputs unchanged until the next falling edge.
- R2: `cmdIn` has no effect on any output, whether during reset or during position discovery.
- R3: After each falling edge at which `rstIn` is sampled 1: `sdoOut` = 1, `regClear` = 1, `indexValid` = 0 and `devIndex` = 0.
- R4: After each falling edge at which `rstIn` is sampled 0: `regClear` = 0 and `sdoOut` equals the `sdiIn` value sampled at that same edge.
- R5: The first falling edge with `rstIn` sampled 0 after a reset is the release edge. If `sdiIn` is sampled 0 at the release edge, the block reports `devIndex` = 0 with `indexValid` = 1 right after that edge.
- R6: Otherwise the block counts falling edges after the release edge. At the first edge where `sdiIn` is sampled 0, it latches the number of edges since the release edge into `devIndex` and raises `indexValid`. `indexValid` only rises on an edge where `sdiIn` is sampled 0.
- R7: When N instances are chained (instance 0 with `sdiIn` tied 0, and each `sdoOut` driving the next instance's `sdiIn`), instance k reports index k. It does so right after the k-th falling edge following the release edge, counting the release edge as edge 0. The last `sdoOut` falls at that same edge for k = N-1.
- R8: Once `indexValid` is 1, `devIndex` and `indexValid` hold their values until `rstIn` is next sampled 1, whatever `sdiIn` does.
- R9: Sampling `rstIn` as 1 at any time, including in the middle of discovery, restarts the sequence from the R3 state.
- R10: The position count saturates at `MAX_POS`-1. A device whose serial input stays high for longer reports `MAX_POS`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sckIn | input | 1 | Serial clock; all inputs are sampled on its falling edge |
| rstIn | input | 1 | Serial reset from the controller, active high after the receiver |
| cmdIn | input | 1 | Serial command line; not used by this block |
| sdiIn | input | 1 | Serial input from the previous device (tied 0 on the first one) |
| sdoOut | output | 1 | Serial output toward the next device or the controller |
| regClear | output | 1 | High while local control registers are held at their reset values |
| devIndex | output | $clog2(MAX_POS) | Discovered position in the chain |
| indexValid | output | 1 | High once `devIndex` has been latched |

## Verification
The bench builds a chain of four instances and checks the ripple edge by edge. A one-cycle error in the serial-out register or the counter start would show up as every device reporting an index off by one, or as the controller's read line falling one edge early or late. A reset pulse in the middle of discovery must clear partial results; a design that only clears at power-up would keep stale valid flags. A stand-alone instance with a small `MAX_POS` holds its serial input high past the count limit. A wrapping counter would report a small index instead of the saturated one. Toggling the serial input after the index is latched would expose a design that re-latches.

// File: rtl/chain_pos_pkg.sv
package chain_pos_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_SEEK = 2'd2,
    ST_DONE = 2'd3
  } seqState_t;

  // one action per falling edge, issued by control to the datapath
  typedef struct packed {
    logic clearAll;
    logic loadOne;
    logic incCnt;
    logic latchCnt;
    logic latchZero;
  } seqStrobe_t;

endpackage

// File: rtl/chain_pos_ctrl.sv
module chain_pos_ctrl
  import chain_pos_pkg::*;
(
  input  logic       sckIn,
  input  logic       rstIn,
  input  logic       sdiIn,
  input  logic       cntAtMax,
  output seqStrobe_t stb
);

  seqState_t stateQ;
  seqState_t stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = stateQ;
    if (rstIn) begin
      stb.clearAll = 1'b1;
      stateNxt     = ST_HOLD;
    end else begin
      unique case (stateQ)
        ST_HOLD: begin
          if (!sdiIn) begin
            stb.latchZero = 1'b1;
            stateNxt      = ST_DONE;
          end else begin
            stb.loadOne = 1'b1;
            stateNxt    = ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (!sdiIn) begin
            stb.latchCnt = 1'b1;
            stateNxt     = ST_DONE;
          end else if (!cntAtMax) begin
            stb.incCnt = 1'b1;
          end
        end
        default: stateNxt = stateQ;
      endcase
    end
  end

  always_ff @(negedge sckIn) begin
    stateQ <= stateNxt;
  end

  // at most one action per edge
  always_comb begin
    p_one_action_r6: assert ($onehot0(stb));
  end

endmodule

// File: rtl/chain_pos_dp.sv
module chain_pos_dp
  import chain_pos_pkg::*;
#(
  parameter int MAX_POS = 16
) (
  input  logic                         sckIn,
  input  logic                         rstIn,
  input  logic                         sdiIn,
  input  seqStrobe_t                   stb,
  output logic                         cntAtMax,
  output logic                         sdoOut,
  output logic                         regClear,
  output logic [$clog2(MAX_POS)-1:0]   devIndex,
  output logic                         indexValid
);

  localparam int POS_W = $clog2(MAX_POS);
  localparam logic [POS_W-1:0] MAX_IDX = POS_W'(MAX_POS - 1);
  localparam logic [POS_W-1:0] ONE_IDX = POS_W'(1);

  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] devIndexQ;
  logic             validQ;
  logic             sdoQ;
  logic             regClearQ;

  always_ff @(negedge sckIn) begin
    regClearQ <= stb.clearAll;
    sdoQ      <= stb.clearAll ? 1'b1 : sdiIn;
    if (stb.clearAll) begin
      posCnt    <= '0;
      devIndexQ <= '0;
      validQ    <= 1'b0;
    end else begin
      if (stb.loadOne) posCnt <= ONE_IDX;
      if (stb.incCnt)  posCnt <= posCnt + ONE_IDX;
      if (stb.latchZero) begin
        devIndexQ <= '0;
        validQ    <= 1'b1;
      end
      if (stb.latchCnt) begin
        devIndexQ <= posCnt;
        validQ    <= 1'b1;
      end
    end
  end

  assign cntAtMax   = (posCnt == MAX_IDX);
  assign sdoOut     = sdoQ;
  assign regClear   = regClearQ;
  assign devIndex   = devIndexQ;
  assign indexValid = validQ;

  // R3: the edge before the last one sampled reset, so the clear state must show
  p_reset_state_r3: assert property (@(negedge sckIn) disable iff (rstIn)
    $past(rstIn) |-> (sdoOut && regClear && !indexValid && devIndex == '0));

  // R4: out of reset the serial output is the previous sampled input
  p_sdo_follow_r4: assert property (@(negedge sckIn) disable iff (rstIn)
    !$past(rstIn) |-> (sdoOut == $past(sdiIn) && !regClear));

  // R6: valid only rises after an edge that saw serial input low
  p_rise_on_low_r6: assert property (@(negedge sckIn) disable iff (rstIn)
    $rose(indexValid) |-> !$past(sdiIn));

  // R8: a latched index holds until the next reset
  p_index_hold_r8: assert property (@(negedge sckIn) disable iff (rstIn)
    indexValid |=> (indexValid && $stable(devIndex)));

  // R10: a saturated count never wraps
  p_no_wrap_r10: assert property (@(negedge sckIn) disable iff (rstIn)
    (posCnt == MAX_IDX) |=> (posCnt == MAX_IDX));

endmodule

// File: rtl/chain_pos_seq.sv
module chain_pos_seq
  import chain_pos_pkg::*;
#(
  parameter int MAX_POS = 16
) (
  input  logic                       sckIn,
  input  logic                       rstIn,
  input  logic                       cmdIn,
  input  logic                       sdiIn,
  output logic                       sdoOut,
  output logic                       regClear,
  output logic [$clog2(MAX_POS)-1:0] devIndex,
  output logic                       indexValid
);

  seqStrobe_t stb;
  logic       cntAtMax;
  logic       unusedCmd;

  // R2: the command line plays no part in reset or discovery
  assign unusedCmd = cmdIn;

  chain_pos_ctrl u_ctrl (
    .sckIn    (sckIn),
    .rstIn    (rstIn),
    .sdiIn    (sdiIn),
    .cntAtMax (cntAtMax),
    .stb      (stb)
  );

  chain_pos_dp #(
    .MAX_POS (MAX_POS)
  ) u_dp (
    .sckIn      (sckIn),
    .rstIn      (rstIn),
    .sdiIn      (sdiIn),
    .stb        (stb),
    .cntAtMax   (cntAtMax),
    .sdoOut     (sdoOut),
    .regClear   (regClear),
    .devIndex   (devIndex),
    .indexValid (indexValid)
  );

endmodule

// File: tb/tb_chain_pos_seq.sv
`timescale 1ns/1ps
module tb_chain_pos_seq;

  localparam int NDEV    = 4;
  localparam int CHAIN_P = 8;
  localparam int CW      = $clog2(CHAIN_P);
  localparam int SOLO_P  = 4;
  localparam int SW      = $clog2(SOLO_P);

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz serial clock

  logic rst = 1'b0;
  logic cmd = 1'b0;
  logic [NDEV-1:0] sdoC;
  logic [NDEV-1:0] clrC;
  logic [NDEV-1:0] validC;
  logic [CW-1:0]   idxC [NDEV];

  for (genvar i = 0; i < NDEV; i++) begin : g_chain
    logic sdiW;
    if (i == 0) begin : g_first
      assign sdiW = 1'b0;
    end else begin : g_next
      assign sdiW = sdoC[i-1];
    end
    chain_pos_seq #(.MAX_POS(CHAIN_P)) dut (
      .sckIn      (clk),
      .rstIn      (rst),
      .cmdIn      (cmd),
      .sdiIn      (sdiW),
      .sdoOut     (sdoC[i]),
      .regClear   (clrC[i]),
      .devIndex   (idxC[i]),
      .indexValid (validC[i])
    );
  end

  logic srd;
  assign srd = sdoC[NDEV-1];

  logic soloRst = 1'b0;
  logic soloSdi = 1'b1;
  logic soloSdo, soloClr, soloValid;
  logic [SW-1:0] soloIdx;

  chain_pos_seq #(.MAX_POS(SOLO_P)) solo (
    .sckIn      (clk),
    .rstIn      (soloRst),
    .cmdIn      (1'b0),
    .sdiIn      (soloSdi),
    .sdoOut     (soloSdo),
    .regClear   (soloClr),
    .devIndex   (soloIdx),
    .indexValid (soloValid)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // hold reset for n falling edges, then drive it low for the release edge
  task automatic chainReset(input int n, input bit cmdVal);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      rst = 1'b1;
      cmd = cmdVal;
    end
    @(posedge clk);
    rst = 1'b0;
  endtask

  // after chainReset: watch the zero ripple edge by edge
  task automatic chainRipple(input bit toggleCmd, input string tag);
    for (int j = 0; j < NDEV; j++) begin
      @(posedge clk);
      if (toggleCmd) cmd = ~cmd;
      for (int k = 0; k < NDEV; k++) begin
        check(validC[k] == (k <= j), {tag, " valid"}, validC[k], (k <= j));
        check(sdoC[k] == (k > j), {tag, " sdo"}, sdoC[k], (k > j));
        if (k <= j) check(idxC[k] == CW'(k), {tag, " index"}, idxC[k], k);
      end
    end
    check(srd == 1'b0, {tag, " R7 controller read line"}, srd, 0);
  endtask

  task automatic testResetState();
    repeat (6) @(posedge clk);
    check(srd == 1'b0, "R4 idle chain copies low", srd, 0);
    rst = 1'b1;
    #5;
    // R1: reset not yet sampled before the falling edge
    check(clrC[0] == 1'b0, "R1 no change before falling edge", clrC[0], 0);
    check(srd == 1'b0, "R1 sdo unchanged before falling edge", srd, 0);
    @(posedge clk);
    for (int k = 0; k < NDEV; k++) begin
      check(clrC[k] == 1'b1, "R3 regClear", clrC[k], 1);
      check(sdoC[k] == 1'b1, "R3 sdo high", sdoC[k], 1);
      check(validC[k] == 1'b0, "R3 valid low", validC[k], 0);
      check(idxC[k] == '0, "R3 index zero", idxC[k], 0);
    end
    chainReset(4, 1'b0);
    @(posedge clk);
    check(clrC[0] == 1'b0, "R4 regClear drops on release", clrC[0], 0);
    check(validC[0] == 1'b1 && idxC[0] == '0, "R5 first device index 0", idxC[0], 0);
    rst = 1'b1;
    @(posedge clk);
    check(validC[0] == 1'b0, "R9 reset again clears valid", validC[0], 0);
  endtask

  task automatic testChain();
    chainReset(5, 1'b0);
    chainRipple(1'b0, "R7 chain");
  endtask

  task automatic testCmdIgnored();
    chainReset(5, 1'b1);
    chainRipple(1'b1, "R2 cmd toggling");
    cmd = 1'b0;
  endtask

  task automatic testRestart();
    chainReset(5, 1'b0);
    @(posedge clk);
    @(posedge clk);
    check(validC[1] == 1'b1, "R9 partial discovery", validC[1], 1);
    rst = 1'b1;
    @(posedge clk);
    for (int k = 0; k < NDEV; k++) begin
      check(validC[k] == 1'b0, "R9 restart clears valid", validC[k], 0);
      check(idxC[k] == '0, "R9 restart clears index", idxC[k], 0);
      check(sdoC[k] == 1'b1, "R9 restart sdo high", sdoC[k], 1);
    end
    chainReset(1, 1'b0);
    chainRipple(1'b0, "R9 rediscovery");
  endtask

  task automatic soloRelease(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      soloRst = 1'b1;
      soloSdi = 1'b1;
    end
    @(posedge clk);
    soloRst = 1'b0;
  endtask

  task automatic testSoloCount();
    soloRelease(5);
    @(posedge clk);
    check(soloValid == 1'b0, "R6 not valid at release", soloValid, 0);
    @(posedge clk);
    check(soloValid == 1'b0, "R6 not valid one edge later", soloValid, 0);
    soloSdi = 1'b0;
    @(posedge clk);
    check(soloValid == 1'b1, "R6 valid on low input", soloValid, 1);
    check(soloIdx == SW'(2), "R6 index counts edges", soloIdx, 2);
    // R4 and R8: follow the input, keep the index
    soloSdi = 1'b1;
    @(posedge clk);
    check(soloSdo == 1'b1, "R4 sdo follows 1", soloSdo, 1);
    soloSdi = 1'b0;
    @(posedge clk);
    check(soloSdo == 1'b0, "R4 sdo follows 0", soloSdo, 0);
    soloSdi = 1'b1;
    @(posedge clk);
    check(soloSdo == 1'b1, "R4 sdo follows 1 again", soloSdo, 1);
    check(soloIdx == SW'(2) && soloValid, "R8 index held", soloIdx, 2);
  endtask

  task automatic testSaturate();
    soloRelease(3);
    repeat (7) @(posedge clk);
    check(soloValid == 1'b0, "R10 still seeking", soloValid, 0);
    soloSdi = 1'b0;
    @(posedge clk);
    check(soloValid == 1'b1, "R10 valid after long wait", soloValid, 1);
    check(soloIdx == SW'(SOLO_P - 1), "R10 saturated index", soloIdx, SOLO_P - 1);
  endtask

  initial begin
    testResetState();
    testChain();
    testCmdIgnored();
    testRestart();
    testSoloCount();
    testSaturate();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule